// File: doc/BRIEF.md
# Dual-Width ALU with Flags

This block is the arithmetic-logic stage of a small 16-bit processor. Each cycle it takes two operands, a 4-bit operation code, a byte/word select and the current flag word. It returns the result and a rewritten flag word one clock later. The operations are add, add with carry, increment, subtract, subtract with borrow, decrement, negate, complement, AND and OR. Every one of them can run on the low byte of the operands or on the full 16-bit word.

The flag word has a fixed sparse layout. Carry is at bit 0, zero at bit 6, sign at bit 7, interrupt-enable at bit 9 and overflow at bit 11. The interrupt-enable bit is copied through from the incoming flag word. Every other bit always reads zero.

The operation is chosen from the operands and the opcode by combinational logic, and a single output register holds the result and flags. The block therefore has a fixed latency of one cycle and no handshake.

Top module: `dwalu_core`

## Requirements
- R1: Opcode 0 (add) gives opa+opb and opcode 1 (add with carry) gives opa+opb+flags_in[0]; in both, CF (bit 0) is the carry out of the operand width.
- R2: Opcode 3 (sub) gives opa-opb, opcode 4 (sub with borrow) gives opa-opb-flags_in[0] and opcode 6 (negate) gives 0-opa; CF is set when a borrow occurs, which for negate means opa is nonzero.
- R3: Opcode 2 (increment) gives opa+1 with CF set on carry out; opcode 5 (decrement) gives opa-1 with CF set when opa is zero.
- R4: Opcode 7 gives ~opa, opcode 8 gives opa&opb and opcode 9 gives opa|opb, and all three clear CF and OF (bit 11).
- R5: For additive operations, OF is set when both addends have the same sign and the sign of the result differs from theirs. For subtractive operations, OF is set when the operands' signs differ and the sign of the result differs from the minuend's.
- R6: ZF (bit 6) is set when the result within the selected width is zero. SF (bit 7) copies the result's top bit: bit 7 in byte mode, bit 15 in word mode.
- R7: With byte_mode high, only opa[7:0] and opb[7:0] are used, result[15:8] is zero, and carry and overflow are taken at bit 7.
- R8: Output flag bit 9 copies flags_in[9]; bits 1-5, 8, 10 and 12-15 of flags_out are always zero.
- R9: result and flags_out are registered: they show the operation applied on the previous rising clock edge, and they read zero while rst_n is low.
- R10: Opcodes 10 to 15 produce a zero result and pass flags_in bits 0, 6, 7, 9 and 11 through unchanged, with the other flag bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa | input | 16 | First operand (minuend for subtraction) |
| opb | input | 16 | Second operand |
| opcode | input | 4 | Operation select (0 to 9 defined) |
| byte_mode | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| flags_in | input | 16 | Current flag word (carry and interrupt-enable are read) |
| result | output | 16 | Registered result |
| flags_out | output | 16 | Registered updated flag word |

## Verification
The hardest cases are the ones that sit exactly on the byte boundary while the upper byte carries misleading data. Examples are a byte add whose carry must come out of bit 7 even though opa[15:8] is full of ones, a byte decrement of zero, and a subtract with borrow whose incoming carry turns an equal-operand subtraction into a borrow. Random operands almost never reach these values. The stimulus therefore pairs a directed list of boundary operands with nonzero upper bytes and both carry-in values, followed by a sweep of every opcode at both widths with random operands and random incoming flag words.

// File: rtl/dwalu_pkg.sv
package dwalu_pkg;

    localparam int DATA_W = 16;
    localparam int HALF_W = DATA_W / 2;

    // flag bit positions decoded by the branch logic elsewhere
    localparam int CF_POS = 0;
    localparam int ZF_POS = 6;
    localparam int SF_POS = 7;
    localparam int IE_POS = 9;
    localparam int OF_POS = 11;

    localparam logic [DATA_W-1:0] FLAG_USED_MASK =
        DATA_W'((1 << CF_POS) | (1 << ZF_POS) | (1 << SF_POS) |
                (1 << IE_POS) | (1 << OF_POS));

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_INC = 4'd2,
        OP_SUB = 4'd3,
        OP_SBB = 4'd4,
        OP_DEC = 4'd5,
        OP_NEG = 4'd6,
        OP_NOT = 4'd7,
        OP_AND = 4'd8,
        OP_OR  = 4'd9
    } alu_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [DATA_W-1:0] flags;
    } alu_out_s;

endpackage

// File: rtl/dwalu_operand_sel.sv
module dwalu_operand_sel
    import dwalu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [3:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          carry_in,
    output logic [DW-1:0] add_x,
    output logic [DW-1:0] add_y,
    output logic          add_cin,
    output logic          borrow_sense,
    output logic          use_adder,
    output logic          op_known,
    output logic [DW-1:0] bitwise_res
);

    localparam logic [DW-1:0] ONE = DW'(1);

    always_comb begin
        add_x        = a;
        add_y        = b;
        add_cin      = 1'b0;
        borrow_sense = 1'b0;
        use_adder    = 1'b1;
        op_known     = 1'b1;
        bitwise_res  = '0;
        case (op)
            OP_ADD: ;
            OP_ADC: add_cin = carry_in;
            OP_INC: add_y = ONE;
            OP_SUB: begin
                add_y        = ~b;
                add_cin      = 1'b1;
                borrow_sense = 1'b1;
            end
            OP_SBB: begin
                add_y        = ~b;
                add_cin      = ~carry_in;
                borrow_sense = 1'b1;
            end
            OP_DEC: begin
                add_y        = ~ONE;
                add_cin      = 1'b1;
                borrow_sense = 1'b1;
            end
            OP_NEG: begin
                add_x        = '0;
                add_y        = ~a;
                add_cin      = 1'b1;
                borrow_sense = 1'b1;
            end
            OP_NOT: begin
                use_adder   = 1'b0;
                bitwise_res = ~a;
            end
            OP_AND: begin
                use_adder   = 1'b0;
                bitwise_res = a & b;
            end
            OP_OR: begin
                use_adder   = 1'b0;
                bitwise_res = a | b;
            end
            default: begin
                use_adder = 1'b0;
                op_known  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dwalu_adder.sv
module dwalu_adder #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic          cin,
    input  logic          narrow,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic          ovf
);

    localparam int HW = DW / 2;

    logic [HW:0] lo_sum;
    logic [DW:0] full_sum;

    always_comb begin
        lo_sum   = {1'b0, x[HW-1:0]} + {1'b0, y[HW-1:0]} + (HW+1)'(cin);
        full_sum = {1'b0, x} + {1'b0, y} + (DW+1)'(cin);
        if (narrow) begin
            sum  = {{(DW-HW){1'b0}}, lo_sum[HW-1:0]};
            cout = lo_sum[HW];
            ovf  = (x[HW-1] == y[HW-1]) && (lo_sum[HW-1] != x[HW-1]);
        end else begin
            sum  = full_sum[DW-1:0];
            cout = full_sum[DW];
            ovf  = (x[DW-1] == y[DW-1]) && (full_sum[DW-1] != x[DW-1]);
        end
    end

endmodule

// File: rtl/dwalu_flagpack.sv
module dwalu_flagpack
    import dwalu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] res,
    input  logic          narrow,
    input  logic          op_known,
    input  logic          carry,
    input  logic          ovf,
    input  logic [DW-1:0] flags_prev,
    output logic [DW-1:0] flags_new
);

    localparam int HW = DW / 2;

    always_comb begin
        if (!op_known) begin
            flags_new = flags_prev & FLAG_USED_MASK;
        end else begin
            flags_new         = '0;
            flags_new[IE_POS] = flags_prev[IE_POS];
            flags_new[CF_POS] = carry;
            flags_new[OF_POS] = ovf;
            flags_new[ZF_POS] = narrow ? (res[HW-1:0] == '0) : (res == '0);
            flags_new[SF_POS] = narrow ? res[HW-1] : res[DW-1];
        end
    end

endmodule

// File: rtl/dwalu_core.sv
module dwalu_core
    import dwalu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [3:0]        opcode,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] flags_in,
    output logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] flags_out
);

    localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'((1 << HALF_W) - 1);

    logic [DATA_W-1:0] add_x, add_y, bitwise_res, add_sum, flags_w;
    logic              add_cin, borrow_sense, use_adder, op_known;
    logic              add_cout, add_ovf, carry_w, ovf_w;
    alu_out_s          out_d, out_q;

    dwalu_operand_sel #(.DW(DATA_W)) u_sel (
        .op           (opcode),
        .a            (opa),
        .b            (opb),
        .carry_in     (flags_in[CF_POS]),
        .add_x        (add_x),
        .add_y        (add_y),
        .add_cin      (add_cin),
        .borrow_sense (borrow_sense),
        .use_adder    (use_adder),
        .op_known     (op_known),
        .bitwise_res  (bitwise_res)
    );

    dwalu_adder #(.DW(DATA_W)) u_add (
        .x      (add_x),
        .y      (add_y),
        .cin    (add_cin),
        .narrow (byte_mode),
        .sum    (add_sum),
        .cout   (add_cout),
        .ovf    (add_ovf)
    );

    always_comb begin
        carry_w   = use_adder & (add_cout ^ borrow_sense);
        ovf_w     = use_adder & add_ovf;
        out_d.res = '0;
        if (use_adder)
            out_d.res = add_sum;
        else if (op_known)
            out_d.res = byte_mode ? (bitwise_res & LOW_MASK) : bitwise_res;
        out_d.flags = flags_w;
    end

    dwalu_flagpack #(.DW(DATA_W)) u_flags (
        .res        (out_d.res),
        .narrow     (byte_mode),
        .op_known   (op_known),
        .carry      (carry_w),
        .ovf        (ovf_w),
        .flags_prev (flags_in),
        .flags_new  (flags_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result    = out_q.res;
    assign flags_out = out_q.flags;

endmodule

// File: rtl/dwalu_core_chk.sv
module dwalu_core_chk
    import dwalu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] opa,
    input logic [DATA_W-1:0] opb,
    input logic [3:0]        opcode,
    input logic              byte_mode,
    input logic [DATA_W-1:0] flags_in,
    input logic [DATA_W-1:0] result,
    input logic [DATA_W-1:0] flags_out
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_out & ~FLAG_USED_MASK) == '0);

    // R8
    ie_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> flags_out[IE_POS] == $past(flags_in[IE_POS]));

    // R4
    logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && ($past(opcode) == OP_NOT || $past(opcode) == OP_AND ||
                     $past(opcode) == OP_OR))
        |-> (!flags_out[CF_POS] && !flags_out[OF_POS]));

    // R7
    byte_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(byte_mode)) |-> result[DATA_W-1:HALF_W] == '0);

    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(opcode) <= OP_OR)
        |-> flags_out[ZF_POS] == (result == '0));

    // R6
    sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(opcode) <= OP_OR)
        |-> flags_out[SF_POS] == ($past(byte_mode) ? result[HALF_W-1] : result[DATA_W-1]));

    // R10
    unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(opcode) > OP_OR)
        |-> (result == '0 && flags_out == ($past(flags_in) & FLAG_USED_MASK)));

endmodule

bind dwalu_core dwalu_core_chk u_chk (.*);

// File: tb/dwalu_core_test.sv
module dwalu_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] opa = '0, opb = '0, flags_in = '0;
    logic [3:0]  opcode = '0;
    logic        byte_mode = 1'b0;
    logic [15:0] result, flags_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [3:0]  op;
        logic        bm;
        logic [15:0] a, b, fin, exp_res, exp_flags;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    dwalu_core uut (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .opcode(opcode),
        .byte_mode(byte_mode), .flags_in(flags_in),
        .result(result), .flags_out(flags_out)
    );

    // reference model written from the requirements
    function automatic logic [31:0] model(input logic [15:0] a, input logic [15:0] b,
                                          input logic [3:0] op, input logic bm,
                                          input logic [15:0] fin);
        int w  = bm ? 8 : 16;
        int m  = (1 << w) - 1;
        int sg = 1 << (w - 1);
        int ua = int'(a) & m;
        int ub = int'(b) & m;
        int c  = int'(fin[0]);
        int r  = 0;
        bit cf = 0, of = 0;
        bit sa = (ua & sg) != 0;
        bit sb = (ub & sg) != 0;
        logic [15:0] f = '0;
        if (op > 4'd9) return {16'h0, fin & 16'h0AC1};   // R10
        case (op)
            4'd0: begin r = ua + ub;     cf = r > m; end
            4'd1: begin r = ua + ub + c; cf = r > m; end
            4'd2: begin r = ua + 1;      cf = r > m; of = (ua == sg - 1); end
            4'd3: begin r = ua - ub;     cf = ua < ub; end
            4'd4: begin r = ua - ub - c; cf = ua < ub + c; end
            4'd5: begin r = ua - 1;      cf = (ua == 0); of = (ua == sg); end
            4'd6: begin r = -ua;         cf = (ua != 0); of = (ua == sg); end
            4'd7: r = ~ua;
            4'd8: r = ua & ub;
            default: r = ua | ub;
        endcase
        r = r & m;
        if (op <= 4'd1) of = (sa == sb) && (((r & sg) != 0) != sa);
        if (op == 4'd3 || op == 4'd4) of = (sa != sb) && (((r & sg) != 0) != sa);
        f[0]  = cf;
        f[6]  = (r == 0);
        f[7]  = (r & sg) != 0;
        f[9]  = fin[9];
        f[11] = of;
        return {16'(r), f};
    endfunction

    function automatic string op_tag(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:       return "R1";
            4'd3, 4'd4, 4'd6: return "R2";
            4'd2, 4'd5:       return "R3";
            4'd7, 4'd8, 4'd9: return "R4";
            default:          return "R10";
        endcase
    endfunction

    task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic [3:0] op,
                         input logic bm, input logic [15:0] fin);
        item_t it;
        logic [31:0] e;
        @(negedge clk);
        opa = a; opb = b; opcode = op; byte_mode = bm; flags_in = fin;
        e = model(a, b, op, bm, fin);
        it.op = op; it.bm = bm; it.a = a; it.b = b; it.fin = fin;
        it.exp_res = e[31:16]; it.exp_flags = e[15:0];
        sb_q.push_back(it);
    endtask

    // monitor: output of an item appears after the next rising edge (R9)
    always begin
        @(posedge clk);
        #2;
        if (sb_q.size() > 0) begin
            item_t it;
            string tg;
            logic [15:0] diff;
            it = sb_q.pop_front();
            checks++;
            if (result !== it.exp_res) begin
                fails++;
                tg = it.bm ? {op_tag(it.op), "/R7"} : op_tag(it.op);
                $display("FAIL %s result op=%0d bm=%0d a=%h b=%h actual=%h expected=%h",
                         tg, it.op, it.bm, it.a, it.b, result, it.exp_res);
            end
            checks++;
            if (flags_out !== it.exp_flags) begin
                fails++;
                diff = flags_out ^ it.exp_flags;
                if (it.op > 4'd9)               tg = "R10";
                else if (diff[0])               tg = it.bm ? {op_tag(it.op), "/R7"} : op_tag(it.op);
                else if (diff[11])              tg = "R5";
                else if (diff[6] || diff[7])    tg = "R6";
                else                            tg = "R8";
                $display("FAIL %s flags op=%0d bm=%0d a=%h b=%h fin=%h actual=%h expected=%h",
                         tg, it.op, it.bm, it.a, it.b, it.fin, flags_out, it.exp_flags);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R9: outputs held at zero during reset despite active inputs
        opa = 16'hFFFF; opb = 16'h1234; opcode = 4'd0; flags_in = 16'hFFFF;
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (result !== 16'h0 || flags_out !== 16'h0) begin
            fails++;
            $display("FAIL R9 reset actual=%h/%h expected=0000/0000", result, flags_out);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1 byte carry out of bit 7 with junk upper bytes (R7)
        drive(16'hA5FF, 16'h7301, 4'd0, 1'b1, 16'h0000);
        drive(16'h7FFF, 16'h0001, 4'd0, 1'b0, 16'h0000);   // R5 word overflow
        drive(16'hFFFF, 16'h0001, 4'd0, 1'b0, 16'h0200);   // R6 zero, R8 IE copy
        drive(16'h00FE, 16'h0001, 4'd1, 1'b1, 16'h0001);   // R1 ADC carry in
        drive(16'h1234, 16'h1234, 4'd4, 1'b0, 16'h0001);   // R2 SBB borrow by CF
        drive(16'h1234, 16'h1234, 4'd4, 1'b0, 16'h0000);
        drive(16'hFF80, 16'h0001, 4'd3, 1'b1, 16'h0000);   // R5 byte sub overflow
        drive(16'h8000, 16'h0000, 4'd6, 1'b0, 16'h0000);   // R2 negate of min
        drive(16'hAB00, 16'h0000, 4'd6, 1'b1, 16'h0000);   // R2 negate of zero
        drive(16'hFF00, 16'h0000, 4'd5, 1'b1, 16'h0000);   // R3 byte decrement of zero
        drive(16'h007F, 16'h0000, 4'd2, 1'b1, 16'h0000);   // R3 increment to min
        drive(16'hF0F0, 16'h0FF0, 4'd8, 1'b0, 16'h0801);   // R4 clears CF and OF
        drive(16'h00FF, 16'h0000, 4'd7, 1'b1, 16'h0A01);   // R4 NOT to zero
        drive(16'h1200, 16'h0080, 4'd9, 1'b1, 16'h0000);   // R4 OR sign
        drive(16'h1111, 16'h2222, 4'd12, 1'b0, 16'hFFFF);  // R10
        drive(16'h1111, 16'h2222, 4'd15, 1'b1, 16'h0240);  // R10

        // sweep every opcode at both widths with random data
        for (int op = 0; op < 16; op++) begin
            for (int bm = 0; bm < 2; bm++) begin
                for (int k = 0; k < 12; k++) begin
                    drive(16'($urandom), 16'($urandom), 4'(op), 1'(bm), 16'($urandom));
                end
            end
        end

        @(negedge clk);
        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule